// File: doc/BRIEF.md
# Parallel Register Update Array

This block sits behind a stateful packet-processing lookup. For each packet it takes the lookup's set of register-update microinstructions, one per ALU, together with the flow's current register set and the flow index. Every ALU reads from the same pre-update snapshot of the flow registers and of a small file of switch-wide global registers. The ALUs then run their instructions side by side, and the results are merged into a new flow register set and a new global register file. The new flow register set leaves the block two cycles after the packet was accepted, for the caller to write back into its flow context memory.

The global registers are held inside the block. They persist across packets, clear on reset, and can be read and written through a small configuration port. Because the caller's context memory lags behind the pipeline, a packet can arrive carrying a stale copy of a flow that still has an update in flight. The block keeps the last two results it produced and substitutes the newest matching one, so that a stream of counter increments on one flow loses no step.

An instruction is 43 bits wide: opcode in bits [42:39], destination class in bit [38] (0 flow, 1 global), destination index in [37:36], operand A in [35:18] and operand B in [17:0]. An operand is 18 bits wide: a kind in its top two bits and a value in its low 16 bits. Kind 0 selects a flow register and kind 1 selects a global register, using the low two value bits as the index. Kinds 2 and 3 select the value itself, zero-extended.

Top module: `regupd_array`

## Requirements
- R1: A packet accepted with in_valid high at a clock edge appears two edges later with out_valid high for exactly one cycle and its flow on out_flow. Every accepted packet yields exactly one output, and out_valid is low during and right after reset.
- R2: Opcode 1 (ADD) gives A+B and opcode 2 (SUB) gives A-B, both wrapping modulo 2^32.
- R3: Opcode 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, 6 gives the unsigned minimum, 7 gives the unsigned maximum, and 8 (MOV) copies A.
- R4: Operands decode as described above. Immediates are zero-extended, and a register operand uses only the low two bits of its value as the index.
- R5: All ALUs of one packet read flow and global registers as they stood before that packet's updates.
- R6: When several ALUs of one packet write the same destination, the result of the highest-numbered one is kept. This applies to flow and global destinations alike.
- R7: Global registers clear to zero on reset, keep their values between packets, and take the results of global-destination instructions.
- R8: cfg_rdata shows global register cfg_idx combinationally, and cfg_we writes cfg_wdata at the clock edge. If a packet update writes the same global register at that same edge, the packet's value is kept, while a configuration write to a different register still lands.
- R9: A result shown on out_regs is assumed to be in the caller's memory only for packets presented from the following cycle on. For a packet of the same flow presented one or two cycles after an earlier one, in_regs is ignored and the newest in-flight result is used instead. Packets of other flows are not affected.
- R10: Opcode 0 (NOP) and opcodes 9 to 15 write nothing, and flow registers that no instruction writes leave the block unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Packet update request |
| in_flow | input | 8 | Flow index of the packet |
| in_regs | input | 128 | Current flow registers, register j in bits [32j+31:32j] |
| in_instr | input | 172 | Microinstructions, ALU i in bits [43i+42:43i] |
| cfg_we | input | 1 | Global register write strobe |
| cfg_idx | input | 2 | Global register index for read and write |
| cfg_wdata | input | 32 | Global register write data |
| cfg_rdata | output | 32 | Global register read data |
| out_valid | output | 1 | Updated flow registers are valid |
| out_flow | output | 8 | Flow index of the result |
| out_regs | output | 128 | Updated flow registers for write-back |

## Verification
The bench builds the block at its default sizes: four 32-bit ALUs, four flow registers, four global registers and an 8-bit flow index. These sizes put every destination collision, every operand kind and both global-write orderings within reach of short directed packets. Back-to-back and one-gap streams on a single flow, with deliberately corrupted in_regs, exercise both bypass slots. Interleaved flows show that a bypass hit is keyed on the flow index alone.

// File: rtl/regupd_pkg.sv
package regupd_pkg;

  localparam int OP_W   = 4;
  localparam int KIND_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_MIN = 4'd6,
    OP_MAX = 4'd7,
    OP_MOV = 4'd8
  } upd_op_e;

  // operand kinds; any kind with the top bit set is an immediate
  localparam logic [KIND_W-1:0] SRC_FLOW = 2'd0;
  localparam logic [KIND_W-1:0] SRC_GLOB = 2'd1;

endpackage

// File: rtl/regupd_alu.sv
module regupd_alu import regupd_pkg::*; #(
  parameter int W      = 32,
  parameter int N_FREG = 4,
  parameter int N_GREG = 4,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 2,
  localparam int OPND_W  = KIND_W + IMM_W,
  localparam int INSTR_W = OP_W + 1 + IDX_W + 2 * OPND_W
) (
  input  logic [INSTR_W-1:0]           instr,
  input  logic [N_FREG-1:0][W-1:0]     flow_regs,
  input  logic [N_GREG-1:0][W-1:0]     glob_regs,
  output logic                         wr_en,
  output logic                         wr_glob,
  output logic [IDX_W-1:0]             wr_idx,
  output logic [W-1:0]                 result
);

  localparam int DI_OFF = 2 * OPND_W;
  localparam int DG_OFF = DI_OFF + IDX_W;
  localparam int OP_OFF = DG_OFF + 1;

  logic [OP_W-1:0]             op;
  logic [1:0][OPND_W-1:0]      src;
  logic [1:0][W-1:0]           val;
  logic                        op_known;

  assign op      = instr[OP_OFF +: OP_W];
  assign wr_glob = instr[DG_OFF];
  assign wr_idx  = instr[DI_OFF +: IDX_W];
  assign src[0]  = instr[OPND_W +: OPND_W];
  assign src[1]  = instr[0 +: OPND_W];

  // operand selection, one mux per operand
  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [KIND_W-1:0] kind;
    logic [IDX_W-1:0]  ix;
    assign kind = src[k][OPND_W-1 -: KIND_W];
    assign ix   = src[k][IDX_W-1:0];
    always_comb begin
      val[k] = '0;
      if (kind[KIND_W-1]) begin
        val[k] = W'(src[k][IMM_W-1:0]);
      end else if (kind == SRC_FLOW) begin
        if (int'(ix) < N_FREG) val[k] = flow_regs[ix];
      end else begin
        if (int'(ix) < N_GREG) val[k] = glob_regs[ix];
      end
    end
  end

  always_comb begin
    result   = '0;
    op_known = 1'b1;
    case (op)
      OP_ADD:  result = val[0] + val[1];
      OP_SUB:  result = val[0] - val[1];
      OP_AND:  result = val[0] & val[1];
      OP_OR:   result = val[0] | val[1];
      OP_XOR:  result = val[0] ^ val[1];
      OP_MIN:  result = (val[0] < val[1]) ? val[0] : val[1];
      OP_MAX:  result = (val[0] > val[1]) ? val[0] : val[1];
      OP_MOV:  result = val[0];
      default: op_known = 1'b0;
    endcase
  end

  assign wr_en = op_known &&
                 (wr_glob ? (int'(wr_idx) < N_GREG) : (int'(wr_idx) < N_FREG));

endmodule

// File: rtl/regupd_gfile.sv
module regupd_gfile #(
  parameter int W      = 32,
  parameter int N_GREG = 4,
  parameter int N_ALU  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_en,
  input  logic [N_ALU-1:0]             wr_en,
  input  logic [N_ALU-1:0]             wr_glob,
  input  logic [N_ALU-1:0][IDX_W-1:0]  wr_idx,
  input  logic [N_ALU-1:0][W-1:0]      wr_data,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [W-1:0]                 cfg_wdata,
  output logic [W-1:0]                 cfg_rdata,
  output logic [N_GREG-1:0][W-1:0]     regs
);

  logic [N_GREG-1:0][W-1:0] regs_nxt;
  logic                     regs_en;
  logic                     alu_hit;

  assign regs_en = upd_en | cfg_we;

  // configuration first, then ALUs in ascending order: last writer wins
  always_comb begin
    regs_nxt = regs;
    alu_hit  = 1'b0;
    if (cfg_we && (int'(cfg_idx) < N_GREG)) regs_nxt[cfg_idx] = cfg_wdata;
    if (upd_en) begin
      for (int a = 0; a < N_ALU; a++) begin
        if (wr_en[a] && wr_glob[a]) begin
          regs_nxt[wr_idx[a]] = wr_data[a];
          if (wr_idx[a] == cfg_idx) alu_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (regs_en) begin
      regs <= regs_nxt;
    end
  end

  assign cfg_rdata = (int'(cfg_idx) < N_GREG) ? regs[cfg_idx] : '0;

  // R7: with no packet update and no configuration write the file holds
  a_r7_globals_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_en || cfg_we) |=> $stable(regs));

  // R8: an uncontested configuration write lands
  a_r8_cfg_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !alu_hit && (int'(cfg_idx) < N_GREG))
      |=> regs[$past(cfg_idx)] == $past(cfg_wdata));

endmodule

// File: rtl/regupd_array.sv
module regupd_array import regupd_pkg::*; #(
  parameter int W      = 32,
  parameter int N_ALU  = 4,
  parameter int N_FREG = 4,
  parameter int N_GREG = 4,
  parameter int IMM_W  = 16,
  parameter int FLOW_W = 8,
  localparam int N_MAX   = (N_FREG > N_GREG) ? N_FREG : N_GREG,
  localparam int IDX_W   = (N_MAX < 2) ? 1 : $clog2(N_MAX),
  localparam int OPND_W  = KIND_W + IMM_W,
  localparam int INSTR_W = OP_W + 1 + IDX_W + 2 * OPND_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [FLOW_W-1:0]          in_flow,
  input  logic [N_FREG*W-1:0]        in_regs,
  input  logic [N_ALU*INSTR_W-1:0]   in_instr,
  input  logic                       cfg_we,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [W-1:0]               cfg_wdata,
  output logic [W-1:0]               cfg_rdata,
  output logic                       out_valid,
  output logic [FLOW_W-1:0]          out_flow,
  output logic [N_FREG*W-1:0]        out_regs
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  // stage A: captured request
  logic                          vld_a;
  logic [FLOW_W-1:0]             flow_a;
  logic [N_FREG-1:0][W-1:0]      regs_a;
  logic [N_ALU-1:0][INSTR_W-1:0] instr_a;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_a <= 1'b0;
    else        vld_a <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      flow_a  <= in_flow;
      regs_a  <= in_regs;
      instr_a <= in_instr;
    end
  end

  // result slots: newest (output) and one older (history)
  logic                     hist_valid;
  logic [FLOW_W-1:0]        hist_flow;
  logic [N_FREG-1:0][W-1:0] hist_regs;
  logic [N_FREG-1:0][W-1:0] out_arr;
  logic [N_FREG-1:0][W-1:0] base_regs;

  // read-after-write bypass, newest slot has priority
  always_comb begin
    base_regs = regs_a;
    if (hist_valid && (hist_flow == flow_a)) base_regs = hist_regs;
    if (out_valid  && (out_flow  == flow_a)) base_regs = out_arr;
  end

  // ALU array
  logic [N_GREG-1:0][W-1:0]     gregs;
  logic [N_ALU-1:0]             alu_we;
  logic [N_ALU-1:0]             alu_glob;
  logic [N_ALU-1:0][IDX_W-1:0]  alu_idx;
  logic [N_ALU-1:0][W-1:0]      alu_res;

  for (genvar a = 0; a < N_ALU; a++) begin : g_alu
    regupd_alu #(
      .W(W), .N_FREG(N_FREG), .N_GREG(N_GREG), .IMM_W(IMM_W), .IDX_W(IDX_W)
    ) u_alu (
      .instr     (instr_a[a]),
      .flow_regs (base_regs),
      .glob_regs (gregs),
      .wr_en     (alu_we[a]),
      .wr_glob   (alu_glob[a]),
      .wr_idx    (alu_idx[a]),
      .result    (alu_res[a])
    );
  end

  // flow write resolution, higher ALU index wins
  logic [N_FREG-1:0][W-1:0] flow_nxt;

  always_comb begin
    flow_nxt = base_regs;
    for (int a = 0; a < N_ALU; a++) begin
      if (alu_we[a] && !alu_glob[a]) flow_nxt[alu_idx[a]] = alu_res[a];
    end
  end

  // output and history registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid  <= 1'b0;
      hist_valid <= 1'b0;
    end else begin
      out_valid  <= vld_a;
      hist_valid <= out_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_a) begin
      out_flow <= flow_a;
      out_arr  <= flow_nxt;
    end
    if (out_valid) begin
      hist_flow <= out_flow;
      hist_regs <= out_arr;
    end
  end

  assign out_regs = out_arr;

  regupd_gfile #(
    .W(W), .N_GREG(N_GREG), .N_ALU(N_ALU), .IDX_W(IDX_W)
  ) u_gfile (
    .clk       (clk),
    .rst_n     (rst_s),
    .upd_en    (vld_a),
    .wr_en     (alu_we),
    .wr_glob   (alu_glob),
    .wr_idx    (alu_idx),
    .wr_data   (alu_res),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .regs      (gregs)
  );

  // R1: each captured request produces one result on the next edge
  a_r1_issue: assert property (@(posedge clk) disable iff (!rst_s)
    vld_a |=> out_valid);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !vld_a |=> !out_valid);

  // R6: a flow write by the last ALU always survives
  a_r6_last_wins: assert property (@(posedge clk) disable iff (!rst_s)
    (vld_a && alu_we[N_ALU-1] && !alu_glob[N_ALU-1])
      |=> out_arr[$past(alu_idx[N_ALU-1])] == $past(alu_res[N_ALU-1]));

  // R9: same-flow follower with no writes repeats the newest result
  a_r9_newest: assert property (@(posedge clk) disable iff (!rst_s)
    (vld_a && out_valid && (out_flow == flow_a) && (alu_we == '0))
      |=> out_arr == $past(out_arr));

  // R10: no writes means the bypassed input passes through
  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_s)
    (vld_a && (alu_we == '0)) |=> out_arr == $past(base_regs));

endmodule

// File: tb/regupd_array_bench.sv
module regupd_array_bench;

  localparam int W      = 32;
  localparam int N_ALU  = 4;
  localparam int N_FREG = 4;
  localparam int N_GREG = 4;
  localparam int IMM_W  = 16;
  localparam int FLOW_W = 8;
  localparam int IW     = 43;
  localparam int QD     = 256;

  typedef logic [IW-1:0] ins_t;

  logic                      clk;
  logic                      rst_n;
  logic                      in_valid;
  logic [FLOW_W-1:0]         in_flow;
  logic [N_FREG*W-1:0]       in_regs;
  logic [N_ALU*IW-1:0]       in_instr;
  logic                      cfg_we;
  logic [1:0]                cfg_idx;
  logic [W-1:0]              cfg_wdata;
  logic [W-1:0]              cfg_rdata;
  logic                      out_valid;
  logic [FLOW_W-1:0]         out_flow;
  logic [N_FREG*W-1:0]       out_regs;

  regupd_array #(
    .W(W), .N_ALU(N_ALU), .N_FREG(N_FREG), .N_GREG(N_GREG),
    .IMM_W(IMM_W), .FLOW_W(FLOW_W)
  ) u_regupd_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flow(in_flow),
    .in_regs(in_regs), .in_instr(in_instr), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_flow(out_flow), .out_regs(out_regs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  mon_on = 1'b0;

  // reference state
  logic [W-1:0] fmem [256][N_FREG];
  logic [W-1:0] gref [N_GREG];

  // expected outputs
  int                   ex_flow [QD];
  logic [N_FREG*W-1:0]  ex_regs [QD];
  int                   ex_due  [QD];
  string                ex_tag  [QD];
  int wp = 0;
  int rp = 0;

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [17:0] opd(int kind, logic [15:0] v);
    return {2'(kind), v};
  endfunction

  function automatic ins_t mk(logic [3:0] op, logic g, logic [1:0] d,
                              logic [17:0] a, logic [17:0] b);
    return {op, g, d, a, b};
  endfunction

  localparam int FR = 0;
  localparam int GL = 1;
  localparam int IM = 2;
  localparam int IM3 = 3;
  localparam ins_t NOPI = '0;

  function automatic logic [W-1:0] fetch(logic [17:0] o, int fl);
    logic [1:0] ix;
    ix = o[1:0];
    if (o[17]) return {16'h0, o[15:0]};
    if (o[17:16] == 2'd0) return fmem[fl][ix];
    return gref[ix];
  endfunction

  task automatic send(int fl, ins_t i0, ins_t i1, ins_t i2, ins_t i3,
                      bit stale, string tag);
    ins_t         iv [N_ALU];
    logic [W-1:0] r  [N_ALU];
    bit           we [N_ALU];
    iv[0] = i0; iv[1] = i1; iv[2] = i2; iv[3] = i3;
    in_valid = 1'b1;
    in_flow  = FLOW_W'(fl);
    for (int j = 0; j < N_FREG; j++)
      in_regs[j*W +: W] = stale ? (32'hDEAD_0000 | j) : fmem[fl][j];
    in_instr = {i3, i2, i1, i0};
    for (int a = 0; a < N_ALU; a++) begin
      logic [W-1:0] va, vb;
      va = fetch(iv[a][35:18], fl);
      vb = fetch(iv[a][17:0], fl);
      we[a] = 1'b1;
      case (iv[a][42:39])
        4'd1: r[a] = va + vb;
        4'd2: r[a] = va - vb;
        4'd3: r[a] = va & vb;
        4'd4: r[a] = va | vb;
        4'd5: r[a] = va ^ vb;
        4'd6: r[a] = (va < vb) ? va : vb;
        4'd7: r[a] = (va > vb) ? va : vb;
        4'd8: r[a] = va;
        default: begin r[a] = '0; we[a] = 1'b0; end
      endcase
    end
    for (int a = 0; a < N_ALU; a++) begin
      if (we[a]) begin
        if (iv[a][38]) gref[iv[a][37:36]] = r[a];
        else           fmem[fl][iv[a][37:36]] = r[a];
      end
    end
    ex_flow[wp % QD] = fl;
    ex_regs[wp % QD] = {fmem[fl][3], fmem[fl][2], fmem[fl][1], fmem[fl][0]};
    ex_due[wp % QD]  = cyc + 2;
    ex_tag[wp % QD]  = tag;
    wp++;
    @(negedge clk);
  endtask

  task automatic gap(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_rd(int idx, logic [W-1:0] exp, string tag);
    cfg_idx = 2'(idx);
    #1;
    chk(tag, 128'(cfg_rdata), 128'(exp));
  endtask

  task automatic cfg_wr(int idx, logic [W-1:0] v);
    cfg_we    = 1'b1;
    cfg_idx   = 2'(idx);
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    gref[idx] = v;
  endtask

  // output monitor: order, latency, flow and register values (R1)
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (rp == wp) begin
          checks++;
          errors++;
          $display("FAIL R1: got unexpected output for flow %0d expected none", out_flow);
        end else begin
          chk({"R1 ", ex_tag[rp % QD], " latency"}, 128'(cyc), 128'(ex_due[rp % QD]));
          chk({"R1 ", ex_tag[rp % QD], " flow"}, 128'(out_flow), 128'(ex_flow[rp % QD]));
          chk({ex_tag[rp % QD], " regs"}, out_regs, ex_regs[rp % QD]);
          rp++;
        end
      end else if (rp != wp && cyc > ex_due[rp % QD]) begin
        checks++;
        errors++;
        $display("FAIL R1: got no output expected flow %0d", ex_flow[rp % QD]);
        rp++;
      end
    end
  end

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; cfg_idx = '0;
    cfg_wdata = '0; in_flow = '0; in_regs = '0; in_instr = '0;
    for (int f = 0; f < 256; f++)
      for (int j = 0; j < N_FREG; j++) fmem[f][j] = '0;
    for (int j = 0; j < N_GREG; j++) gref[j] = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid after reset", 128'(out_valid), 128'(0));
    for (int j = 0; j < N_GREG; j++) cfg_rd(j, 32'h0, "R7 reset value");
    mon_on = 1'b1;
  endtask

  task automatic t_arith;
    send(1, mk(4'd1, 0, 0, opd(IM, 16'h1234), opd(IM, 16'h0001)),
            mk(4'd2, 0, 1, opd(FR, 16'h0000), opd(IM, 16'h0001)),
            mk(4'd8, 0, 2, opd(IM, 16'hFFFF), opd(IM, 16'h0000)),
            mk(4'd2, 0, 3, opd(IM, 16'h0005), opd(IM, 16'h0007)), 0, "R2 add/sub");
    gap(3);
    send(1, mk(4'd1, 0, 0, opd(FR, 16'h0001), opd(IM, 16'h0002)),
            mk(4'd1, 0, 1, opd(FR, 16'h0001), opd(FR, 16'h0001)),
            mk(4'd2, 0, 2, opd(FR, 16'h0002), opd(FR, 16'h0002)),
            NOPI, 0, "R2 wrap");
    gap(3);
  endtask

  task automatic t_logic;
    send(3, mk(4'd8, 0, 0, opd(IM, 16'hF0F0), opd(IM, 0)),
            mk(4'd8, 0, 1, opd(IM, 16'h0FF0), opd(IM, 0)), NOPI, NOPI, 0, "R3 setup");
    gap(3);
    send(3, mk(4'd3, 0, 2, opd(FR, 0), opd(FR, 1)),
            mk(4'd4, 0, 3, opd(FR, 0), opd(FR, 1)),
            mk(4'd5, 0, 0, opd(FR, 0), opd(FR, 1)),
            mk(4'd6, 0, 1, opd(FR, 0), opd(FR, 1)), 0, "R3 and/or/xor/min");
    gap(3);
    send(3, mk(4'd7, 0, 0, opd(FR, 0), opd(FR, 2)),
            mk(4'd6, 0, 1, opd(FR, 3), opd(IM, 16'h0100)),
            mk(4'd7, 0, 2, opd(IM3, 16'h8001), opd(FR, 2)),
            mk(4'd8, 0, 3, opd(FR, 16'h0102), opd(IM, 0)), 0, "R3 R4 max/imm/index");
    gap(3);
  endtask

  task automatic t_swap;
    send(2, mk(4'd8, 0, 0, opd(IM, 16'h0011), opd(IM, 0)),
            mk(4'd8, 0, 1, opd(IM, 16'h0022), opd(IM, 0)), NOPI, NOPI, 0, "R5 setup");
    gap(3);
    send(2, mk(4'd8, 0, 0, opd(FR, 1), opd(IM, 0)),
            mk(4'd8, 0, 1, opd(FR, 0), opd(IM, 0)),
            mk(4'd1, 0, 2, opd(FR, 0), opd(FR, 1)), NOPI, 0, "R5 swap");
    gap(3);
  endtask

  task automatic t_conflict;
    send(4, mk(4'd8, 0, 2, opd(IM, 16'hAAAA), opd(IM, 0)),
            mk(4'd8, 0, 2, opd(IM, 16'hBBBB), opd(IM, 0)),
            NOPI,
            mk(4'd8, 0, 2, opd(IM, 16'hCCCC), opd(IM, 0)), 0, "R6 alu3 wins");
    gap(3);
    send(4, mk(4'd8, 0, 1, opd(IM, 1), opd(IM, 0)),
            mk(4'd8, 0, 1, opd(IM, 2), opd(IM, 0)),
            mk(4'd8, 0, 1, opd(IM, 3), opd(IM, 0)), NOPI, 0, "R6 alu2 wins");
    gap(3);
  endtask

  task automatic t_global;
    send(5, mk(4'd1, 1, 1, opd(GL, 1), opd(IM, 5)),
            mk(4'd8, 0, 0, opd(GL, 1), opd(IM, 0)), NOPI, NOPI, 0, "R7 first");
    send(5, mk(4'd1, 1, 1, opd(GL, 1), opd(IM, 5)),
            mk(4'd8, 0, 1, opd(GL, 1), opd(IM, 0)),
            mk(4'd8, 1, 3, opd(IM, 1), opd(IM, 0)),
            mk(4'd8, 1, 3, opd(IM, 2), opd(IM, 0)), 0, "R7 second");
    gap(3);
    cfg_rd(1, 32'd10, "R7 accumulated global");
    cfg_rd(3, 32'd2, "R6 global collision");
  endtask

  task automatic t_cfg;
    cfg_wr(2, 32'h1234_5678);
    cfg_rd(2, 32'h1234_5678, "R8 write/read");
    send(6, mk(4'd1, 0, 0, opd(GL, 2), opd(IM, 1)), NOPI, NOPI, NOPI, 0, "R8 global operand");
    gap(3);
    // packet update and configuration write hit g0 at the same edge
    send(6, mk(4'd8, 1, 0, opd(IM, 16'h0077), opd(IM, 0)), NOPI, NOPI, NOPI, 0, "R8 prio pkt");
    in_valid = 1'b0; cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 32'h99;
    @(negedge clk);
    cfg_we = 1'b0;
    gap(2);
    cfg_rd(0, 32'h77, "R8 packet wins same register");
    // same edge, different registers: both land
    send(6, mk(4'd8, 1, 1, opd(IM, 16'h0011), opd(IM, 0)), NOPI, NOPI, NOPI, 0, "R8 split pkt");
    in_valid = 1'b0; cfg_we = 1'b1; cfg_idx = 2'd2; cfg_wdata = 32'h55;
    @(negedge clk);
    cfg_we = 1'b0;
    gref[2] = 32'h55;
    gap(2);
    cfg_rd(1, 32'h11, "R8 packet write to other register");
    cfg_rd(2, 32'h55, "R8 cfg write to other register");
  endtask

  task automatic t_nop;
    send(3, mk(4'd0, 0, 0, opd(IM, 16'h1111), opd(IM, 1)),
            mk(4'hF, 0, 1, opd(IM, 16'h2222), opd(IM, 1)),
            mk(4'h9, 1, 0, opd(IM, 16'h3333), opd(IM, 1)),
            NOPI, 0, "R10 nop/unknown");
    gap(3);
    cfg_rd(0, gref[0], "R10 global untouched");
  endtask

  task automatic t_bypass;
    ins_t inc0, acc1;
    inc0 = mk(4'd1, 0, 0, opd(FR, 0), opd(IM, 1));
    acc1 = mk(4'd1, 0, 1, opd(FR, 1), opd(FR, 0));
    send(7, inc0, acc1, NOPI, NOPI, 0, "R9 first");
    send(7, inc0, acc1, NOPI, NOPI, 1, "R9 back-to-back");
    send(7, inc0, acc1, NOPI, NOPI, 1, "R9 back-to-back 2");
    gap(1);
    send(7, inc0, acc1, NOPI, NOPI, 1, "R9 one gap");
    gap(3);
    send(7, inc0, acc1, NOPI, NOPI, 0, "R9 settled");
    gap(3);
    send(8, inc0, acc1, NOPI, NOPI, 0, "R9 flow8 a");
    send(9, inc0, acc1, NOPI, NOPI, 0, "R9 other flow");
    send(8, inc0, acc1, NOPI, NOPI, 1, "R9 older slot");
    send(9, inc0, acc1, NOPI, NOPI, 1, "R9 older slot 2");
    gap(3);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_swap();
    t_conflict();
    t_global();
    t_cfg();
    t_nop();
    t_bypass();
    gap(5);
    chk("R1 all outputs seen", 128'(rp), 128'(wp));
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: got watchdog timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule